// File: doc/BRIEF.md
# Configurable Logic-Array Output Cell

This block is one output cell of a programmable logic fabric. It takes a single sum-of-products term, a set of static configuration inputs and a small group of candidate clock inputs. It drives a pin value, a pin output enable and an internal feedback bit. The storage node inside the cell can act as an edge-triggered register, as a level-sensitive latch, or it can be skipped so that the output is combinational.

In register mode the node can load the data directly or toggle on it. The pin path can be inverted. The feedback can return either the cell's own node or the pin's input, so the pin can serve as an input while the cell's logic is still used internally. A buried setting makes the storage node capture the pin input in place of the sum term, which synchronises an external signal into the fabric.

The cell runs on one fabric clock `clk`. The candidate clock inputs are sampled signals: the chosen one is registered, and its rising transitions or high level control the storage node. The configuration is expected to change only while `rst` is held.

Top module: `mc_macrocell`

## Requirements
- R1: When `rst` is sampled high on an edge, `pin_out`, `pin_oe` and `fb_out` are all 0 after that edge, whatever the polarity setting, and the storage node is cleared to 0.
- R2: The output delay is one edge. The node value computed from the inputs sampled on edge k appears at the outputs after edge k+1. In combinational mode (`cfg_mode` = 0, and also 3) the node value is the data input sampled on edge k.
- R3: With `cfg_invert`=1, `pin_out` is the inverse of the node value. `fb_out` always carries the node value without inversion.
- R4: In register mode (`cfg_mode` = 1) with `cfg_toggle`=0, a rising transition occurs when the selected clock input is sampled 1 on edge k after being sampled 0 on edge k-1. On that transition the node loads the data sampled on edge k. The node holds its value at all other times. Because the node value of sample k is the stored value from before that sample, a loaded value reaches the pin after edge k+2.
- R5: In register mode with `cfg_toggle`=1, a rising transition inverts the stored value when the data is 1 and leaves it unchanged when the data is 0.
- R6: In latch mode (`cfg_mode` = 2), while the selected clock input is sampled high the node follows the data sampled on the same edge. While it is sampled low, the node holds the last data taken while it was high.
- R7: `cfg_clk_sel` = i selects `mc_clk[i]`. Activity on any clock input that is not selected has no effect on the outputs.
- R8: With `cfg_fb_pin`=0, `fb_out` carries the node value. With `cfg_fb_pin`=1, it carries the `pin_in` value sampled on edge k, shown after edge k+1.
- R9: Outside reset, `pin_oe` is 1 exactly when both `cfg_buried` and `cfg_fb_pin` are 0.
- R10: With `cfg_buried`=1, the storage node takes `pin_in` in place of `sop` and always loads the value directly; `cfg_toggle` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| sop | input | 1 | Sum-of-products term |
| pin_in | input | 1 | Value read from the pin |
| mc_clk | input | NUM_CLK | Candidate clock inputs (sampled) |
| cfg_clk_sel | input | SEL_W | Index of the clock input in use |
| cfg_mode | input | 2 | 0 combinational, 1 register, 2 latch, 3 combinational |
| cfg_toggle | input | 1 | Register toggles instead of loading |
| cfg_invert | input | 1 | Invert the pin path |
| cfg_buried | input | 1 | Storage captures pin input |
| cfg_fb_pin | input | 1 | Feedback returns pin input |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin output enable |
| fb_out | output | 1 | Internal feedback bit |

## Verification
A stored bit that is wrong in register or latch mode stays wrong at both `pin_out` and `fb_out` until the next capture. It becomes visible two edges after the bad capture. A misdetected clock transition, such as one taken from the unselected input or missed on the selected one, shows within the same two edges as a pin value that differs from the independent model. An inverted feedback, or an enable left on while the pin is an input, differs from the model on the first edge after reset release.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MODE_COMB  = 2'd0,
    MODE_REG   = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_RSVD  = 2'd3
  } mc_mode_e;

endpackage

// File: rtl/mc_input_stage.sv
module mc_input_stage #(
  parameter int NUM_CLK = 2,
  localparam int SEL_W = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CLK-1:0] clk_src,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic               use_pin,
  input  logic               sop,
  input  logic               pin_in,
  output logic               sel_level,
  output logic               sel_rise,
  output logic               data_q,
  output logic               pin_q
);

  logic sel_now;
  logic sel_q;
  logic sel_prev_q;

  always_comb begin
    sel_now = 1'b0;
    for (int i = 0; i < NUM_CLK; i++) begin
      if (clk_sel == SEL_W'(i)) sel_now = clk_src[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= 1'b0;
      sel_prev_q <= 1'b0;
      data_q     <= 1'b0;
      pin_q      <= 1'b0;
    end else begin
      sel_q      <= sel_now;
      sel_prev_q <= sel_q;
      data_q     <= use_pin ? pin_in : sop;
      pin_q      <= pin_in;
    end
  end

  assign sel_level = sel_q;
  assign sel_rise  = sel_q & ~sel_prev_q;

  // R4: a detected transition never lasts two consecutive cycles
  a_r4_rise_single : assert property (@(posedge clk) disable iff (rst)
    sel_rise |=> !sel_rise);

endmodule

// File: rtl/mc_storage.sv
module mc_storage
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  mc_mode_e mode,
  input  logic     tgl,
  input  logic     rise,
  input  logic     level,
  input  logic     d,
  output logic     st,
  output logic     node
);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= 1'b0;
    end else begin
      case (mode)
        MODE_REG:   if (rise)  st <= tgl ? (st ^ d) : d;
        MODE_LATCH: if (level) st <= d;
        default:    st <= st;
      endcase
    end
  end

  always_comb begin
    case (mode)
      MODE_REG:   node = st;
      MODE_LATCH: node = level ? d : st;
      default:    node = d;
    endcase
  end

  a_r4_reg_hold : assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_REG && !rise) |=> $stable(st));

  a_r5_toggle_flip : assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_REG && tgl && rise && d) |=> (st != $past(st)));

  a_r6_latch_hold : assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LATCH && !level) |=> $stable(st));

  a_r1_store_clear : assert property (@(posedge clk)
    rst |=> (st == 1'b0));

endmodule

// File: rtl/mc_output_stage.sv
module mc_output_stage (
  input  logic clk,
  input  logic rst,
  input  logic node,
  input  logic invert,
  input  logic pin_q,
  input  logic fb_pin,
  input  logic buried,
  output logic pin_out,
  output logic pin_oe,
  output logic fb_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
      fb_out  <= 1'b0;
    end else begin
      pin_out <= node ^ invert;
      pin_oe  <= ~(buried | fb_pin);
      fb_out  <= fb_pin ? pin_q : node;
    end
  end

  a_r1_reset_clear : assert property (@(posedge clk)
    rst |=> (!pin_out && !pin_oe && !fb_out));

  a_r9_oe_off : assert property (@(posedge clk) disable iff (rst)
    (buried || fb_pin) |=> !pin_oe);

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int NUM_CLK = 2,
  localparam int SEL_W = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sop,
  input  logic               pin_in,
  input  logic [NUM_CLK-1:0] mc_clk,
  input  logic [SEL_W-1:0]   cfg_clk_sel,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_toggle,
  input  logic               cfg_invert,
  input  logic               cfg_buried,
  input  logic               cfg_fb_pin,
  output logic               pin_out,
  output logic               pin_oe,
  output logic               fb_out
);

  mc_mode_e mode;
  logic     level;
  logic     rise;
  logic     data_q;
  logic     pin_q;
  logic     st;
  logic     node;
  logic     tgl_eff;

  assign mode    = mc_mode_e'(cfg_mode);
  assign tgl_eff = cfg_toggle & ~cfg_buried;

  mc_input_stage #(.NUM_CLK(NUM_CLK)) u_in (
    .clk       (clk),
    .rst       (rst),
    .clk_src   (mc_clk),
    .clk_sel   (cfg_clk_sel),
    .use_pin   (cfg_buried),
    .sop       (sop),
    .pin_in    (pin_in),
    .sel_level (level),
    .sel_rise  (rise),
    .data_q    (data_q),
    .pin_q     (pin_q)
  );

  mc_storage u_st (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .tgl   (tgl_eff),
    .rise  (rise),
    .level (level),
    .d     (data_q),
    .st    (st),
    .node  (node)
  );

  mc_output_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .node    (node),
    .invert  (cfg_invert),
    .pin_q   (pin_q),
    .fb_pin  (cfg_fb_pin),
    .buried  (cfg_buried),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb_out  (fb_out)
  );

  // R3: the pin and the feedback differ exactly by the polarity setting
  a_r3_fb_uninverted : assert property (@(posedge clk) disable iff (rst)
    (!cfg_fb_pin && !$past(rst)) |-> (fb_out == (pin_out ^ cfg_invert)));

endmodule

// File: tb/tb_mc_macrocell.sv
module tb_mc_macrocell;

  localparam int NUM_CLK = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sop = 1'b0;
  logic       pin_in = 1'b0;
  logic [1:0] mc_clk = 2'b00;
  logic [0:0] cfg_clk_sel = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_toggle = 1'b0;
  logic       cfg_invert = 1'b0;
  logic       cfg_buried = 1'b0;
  logic       cfg_fb_pin = 1'b0;
  logic       pin_out, pin_oe, fb_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string cur_tag = "R1";
  logic [31:0] lfsr = 32'h1ACE_B00C;

  int       q_due[$];
  logic [2:0] q_exp[$];
  string    q_tag[$];

  logic m_st = 1'b0;
  logic m_prev = 1'b0;

  always #2 clk = ~clk;

  mc_macrocell #(.NUM_CLK(NUM_CLK)) dut (
    .clk(clk), .rst(rst), .sop(sop), .pin_in(pin_in), .mc_clk(mc_clk),
    .cfg_clk_sel(cfg_clk_sel), .cfg_mode(cfg_mode), .cfg_toggle(cfg_toggle),
    .cfg_invert(cfg_invert), .cfg_buried(cfg_buried), .cfg_fb_pin(cfg_fb_pin),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s {pin_out,pin_oe,fb_out} actual=%b expected=%b at cycle %0d",
               tag, act, exp, cyc);
    end
  endtask

  // Reference model: evaluates each sample edge and schedules the expected outputs
  always @(posedge clk) begin
    logic sel, rise, dat, node;
    cyc = cyc + 1;
    if (rst) begin
      m_st = 1'b0;
      m_prev = 1'b0;
      if (q_due.size() != 0 && q_due[$] == cyc) begin
        void'(q_due.pop_back());
        void'(q_exp.pop_back());
        void'(q_tag.pop_back());
      end
    end else begin
      sel  = mc_clk[cfg_clk_sel];               // R7
      rise = sel && !m_prev;
      dat  = cfg_buried ? pin_in : sop;         // R10
      case (cfg_mode)
        2'd1: begin                             // R4, R5
          node = m_st;
          if (rise) m_st = (cfg_toggle && !cfg_buried) ? (m_st ^ dat) : dat;
        end
        2'd2: begin                             // R6
          node = sel ? dat : m_st;
          if (sel) m_st = dat;
        end
        default: node = dat;                    // R2
      endcase
      m_prev = sel;
      q_due.push_back(cyc + 1);
      q_exp.push_back({node ^ cfg_invert,                     // R3
                       !(cfg_buried || cfg_fb_pin),            // R9
                       cfg_fb_pin ? pin_in : node});           // R8
      q_tag.push_back(cur_tag);
    end
  end

  // Monitor: compares the scheduled items as the design produces them
  always @(negedge clk) begin
    if (q_due.size() != 0 && q_due[0] == cyc) begin
      void'(q_due.pop_front());
      check(q_tag.pop_front(), {pin_out, pin_oe, fb_out}, q_exp.pop_front());
    end
  end

  task automatic run_phase(input string tag, input logic [1:0] mode, input logic tgl,
                           input logic inv, input logic sel, input logic bur,
                           input logic fbp, input int n);
    @(negedge clk);
    rst = 1'b1;
    cur_tag = tag;
    cfg_mode = mode; cfg_toggle = tgl; cfg_invert = inv;
    cfg_clk_sel = sel; cfg_buried = bur; cfg_fb_pin = fbp;
    @(negedge clk);
    @(negedge clk);
    check("R1", {pin_out, pin_oe, fb_out}, 3'b000);
    rst = 1'b0;
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sop    = lfsr[3];
      pin_in = lfsr[9];
      mc_clk = (i % 7 == 3) ? 2'b00 : lfsr[17:16];
      @(negedge clk);
    end
    sop = 1'b0; pin_in = 1'b0; mc_clk = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {pin_out, pin_oe, fb_out}, 3'b000);
    run_phase("R2", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 200);
    run_phase("R2", 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 100);
    run_phase("R3", 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 200);
    run_phase("R4", 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 400);
    run_phase("R5", 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 400);
    run_phase("R6", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 400);
    run_phase("R7", 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 400);
    run_phase("R7", 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 300);
    run_phase("R8", 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 300);
    run_phase("R9", 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 300);
    run_phase("R10", 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 400);
    run_phase("R10", 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 300);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule